// File: doc/BRIEF.md
# Half-Word Saturating Immediate Left Shifter

This block is an execution unit with eight 32-bit registers. Each instruction takes one 16-bit half of a source register and shifts it left arithmetically by a 4-bit immediate. It clamps the result to the signed 16-bit range instead of letting it wrap. The result is written into one chosen half of a destination register, and the other half of that register keeps its value.

The unit accepts one instruction per clock. Each instruction commits at the next rising edge, and a later instruction reads the value the earlier one wrote, with no stall. A full-word load port fills registers before a run. A combinational read port shows the current contents of any register.

Top module: `hsh_exec`

## Requirements
- R1: A load (`ld_en`=1) writes `ld_data` into register `ld_addr` at the rising edge, and `rd_data` shows the new word from that edge on.
- R2: `iss_src_hi`=1 takes the operand from bits [31:16] of the source register, and `iss_src_hi`=0 takes it from bits [15:0].
- R3: A shift amount of 0 writes the operand unchanged.
- R4: When the shifted value fits in a signed 16-bit number, the result is the operand shifted left with zeros filling the vacated low bits (0x0A03 by 3 gives 0x5018, 0x00B1 by 1 gives 0x0162).
- R5: A non-negative operand whose shifted value exceeds 32767 gives 0x7FFF. This includes the case where a 1 reaches bit 15 (0x0A04 by 4 gives 0x7FFF).
- R6: A negative operand whose shifted value is below -32768 gives 0x8000. A value of exactly -32768 is not clamped (0xFFFF by 15 gives 0x8000).
- R7: `iss_dst_hi`=1 writes the result into bits [31:16] of the destination, and `iss_dst_hi`=0 writes it into bits [15:0]. The other 16 bits of the destination are left as they were.
- R8: The source and destination may be the same register, in either half. The operand is the value from before the write. Back-to-back instructions see each other's results.
- R9: If `ld_en` and `iss_valid` are both high in the same cycle, the load is performed and the instruction is dropped.
- R10: An active-high synchronous reset clears all eight registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Full-word load strobe |
| ld_addr | input | 3 | Load register index |
| ld_data | input | 32 | Load value |
| iss_valid | input | 1 | Instruction issue strobe |
| iss_src | input | 3 | Source register index |
| iss_src_hi | input | 1 | Source half select (1 = upper) |
| iss_dst | input | 3 | Destination register index |
| iss_dst_hi | input | 1 | Destination half select (1 = upper) |
| iss_amt | input | 4 | Immediate shift amount, 0 to 15 |
| rd_addr | input | 3 | Read register index |
| rd_data | output | 32 | Contents of register `rd_addr` |

## Verification
A wrong register value shows on `rd_data` one edge after the instruction that wrote it. The bench reads back all eight registers after every step, so a corrupted preserved half or a write to the wrong register is caught in the same step. A bad saturation or a wrong operand half is caught the same way. Because many random instructions feed on earlier results, a stale or wrongly ordered operand spreads into later values and is also seen within a step or two.

// File: rtl/hsh_pkg.sv
package hsh_pkg;
    localparam int NREG = 8;
    localparam int XLEN = 32;
    localparam int HLEN = XLEN / 2;
    localparam int AW   = $clog2(NREG);
    localparam int SHW  = $clog2(HLEN);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [HLEN-1:0] half_t;

    typedef struct packed {
        logic [AW-1:0]  src;
        logic           src_hi;
        logic [AW-1:0]  dst;
        logic           dst_hi;
        logic [SHW-1:0] amt;
    } instr_t;

    localparam half_t SAT_POS = {1'b0, {(HLEN-1){1'b1}}};
    localparam half_t SAT_NEG = {1'b1, {(HLEN-1){1'b0}}};

    function automatic half_t pick_half(input word_t w, input logic hi);
        return hi ? w[XLEN-1:HLEN] : w[HLEN-1:0];
    endfunction
endpackage

// File: rtl/hsh_regfile.sv
module hsh_regfile
    import hsh_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      ld_en,
    input  logic [AW-1:0]             ld_addr,
    input  word_t                     ld_data,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_addr,
    input  word_t                     wr_data,
    output logic [NREG-1:0][XLEN-1:0] regs_o
);
    logic [NREG-1:0][XLEN-1:0] regs_q;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (ld_en && ld_addr == AW'(g))
                regs_q[g] <= ld_data;
            else if (wr_en && !ld_en && wr_addr == AW'(g))
                regs_q[g] <= wr_data;
        end
    end

    assign regs_o = regs_q;

    // R10
    reset_clear_chk: assert property (@(posedge clk) rst |=> regs_q == '0);
    // R1
    load_write_chk: assert property (@(posedge clk) disable iff (rst)
        ld_en |=> regs_q[$past(ld_addr)] == $past(ld_data));
endmodule

// File: rtl/hsh_shifter.sv
module hsh_shifter
    import hsh_pkg::*;
(
    input  half_t          op,
    input  logic [SHW-1:0] amt,
    output half_t          res
);
    localparam int EW = 2 * HLEN;
    logic signed [EW-1:0] ext;
    logic signed [EW-1:0] shifted;
    logic                 ovf;

    always_comb begin
        ext     = EW'(signed'(op));
        shifted = ext <<< amt;
        ovf     = shifted[EW-1:HLEN-1] != {(EW-HLEN+1){op[HLEN-1]}};
        if (!ovf)
            res = shifted[HLEN-1:0];
        else
            res = op[HLEN-1] ? SAT_NEG : SAT_POS;
    end

    always_comb begin
        if (!$isunknown({op, amt})) begin
            // R5
            pos_sign_keep_chk: assert (op[HLEN-1] || !res[HLEN-1]);
            // R6
            neg_sign_keep_chk: assert (!op[HLEN-1] || res[HLEN-1]);
            // R3
            zero_shift_chk: assert (amt != '0 || res == op);
        end
    end
endmodule

// File: rtl/hsh_merge.sv
module hsh_merge
    import hsh_pkg::*;
(
    input  word_t old_w,
    input  half_t new_h,
    input  logic  hi,
    output word_t new_w
);
    always_comb begin
        new_w = hi ? {new_h, old_w[HLEN-1:0]} : {old_w[XLEN-1:HLEN], new_h};
    end
endmodule

// File: rtl/hsh_exec.sv
module hsh_exec
    import hsh_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_en,
    input  logic [2:0]  ld_addr,
    input  logic [31:0] ld_data,
    input  logic        iss_valid,
    input  logic [2:0]  iss_src,
    input  logic        iss_src_hi,
    input  logic [2:0]  iss_dst,
    input  logic        iss_dst_hi,
    input  logic [3:0]  iss_amt,
    input  logic [2:0]  rd_addr,
    output logic [31:0] rd_data
);
    logic [NREG-1:0][XLEN-1:0] regs;
    instr_t ins;
    half_t  operand, result;
    word_t  merged;

    assign ins = '{src: iss_src, src_hi: iss_src_hi, dst: iss_dst,
                   dst_hi: iss_dst_hi, amt: iss_amt};
    assign operand = pick_half(regs[ins.src], ins.src_hi);

    hsh_shifter u_shift (.op(operand), .amt(ins.amt), .res(result));

    hsh_merge u_merge (.old_w(regs[ins.dst]), .new_h(result),
                       .hi(ins.dst_hi), .new_w(merged));

    hsh_regfile u_rf (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .wr_en(iss_valid), .wr_addr(ins.dst), .wr_data(merged),
        .regs_o(regs)
    );

    assign rd_data = regs[rd_addr];

    // R7
    keep_low_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !ld_en && iss_dst_hi) |=>
        regs[$past(iss_dst)][HLEN-1:0] == $past(regs[iss_dst][HLEN-1:0]));
    // R7
    keep_high_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !ld_en && !iss_dst_hi) |=>
        regs[$past(iss_dst)][XLEN-1:HLEN] == $past(regs[iss_dst][XLEN-1:HLEN]));
    // R9
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && ld_en && iss_dst != ld_addr) |=>
        regs[$past(iss_dst)] == $past(regs[iss_dst]));
endmodule

// File: tb/sim_hsh_exec.sv
module sim_hsh_exec;
    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en, iss_valid, iss_src_hi, iss_dst_hi;
    logic [2:0]  ld_addr, iss_src, iss_dst, rd_addr;
    logic [31:0] ld_data, rd_data;
    logic [3:0]  iss_amt;
    logic [31:0] mdl [8];
    int checks = 0, errors = 0;

    always #4 clk = ~clk;

    hsh_exec u0 (.*);

    function automatic logic [15:0] ref_shift(input logic [15:0] h, input int amt);
        longint v = longint'($signed(h)) * (longint'(1) << amt);
        if (v > 32767) return 16'h7FFF;
        if (v < -32768) return 16'h8000;
        return v[15:0];
    endfunction

    function automatic string tag_of(input logic [15:0] h, input int amt);
        longint v = longint'($signed(h)) * (longint'(1) << amt);
        if (amt == 0) return "R3";
        if (v > 32767) return "R5";
        if (v < -32768) return "R6";
        return "R4";
    endfunction

    task automatic check_reg(input int idx, input logic [31:0] exp, input string tag);
        rd_addr = 3'(idx);
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s r%0d actual %h expected %h", tag, idx, rd_data, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < 8; i++) check_reg(i, mdl[i], tag);
    endtask

    task automatic load(input int a, input logic [31:0] d);
        ld_en = 1'b1; ld_addr = 3'(a); ld_data = d;
        @(negedge clk);
        ld_en = 1'b0;
        mdl[a] = d;
    endtask

    task automatic issue(input int s, input bit shi, input int d, input bit dhi, input int amt);
        logic [15:0] op, r;
        iss_valid = 1'b1; iss_src = 3'(s); iss_src_hi = shi;
        iss_dst = 3'(d); iss_dst_hi = dhi; iss_amt = 4'(amt);
        @(negedge clk);
        iss_valid = 1'b0;
        op = shi ? mdl[s][31:16] : mdl[s][15:0];
        r = ref_shift(op, amt);
        if (dhi) mdl[d][31:16] = r; else mdl[d][15:0] = r;
    endtask

    function automatic logic [15:0] rand_half();
        logic [15:0] m = 16'($urandom_range(0, 32767) >> $urandom_range(0, 14));
        return $urandom_range(0, 1) ? -m : m;
    endfunction

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D5E));
        rst = 1'b1; ld_en = 0; iss_valid = 0; ld_addr = 0; ld_data = 0;
        iss_src = 0; iss_src_hi = 0; iss_dst = 0; iss_dst_hi = 0; iss_amt = 0; rd_addr = 0;
        for (int i = 0; i < 8; i++) mdl[i] = 32'hDEAD_BEEF;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) mdl[i] = '0;
        check_all("R10");

        // R1 loads
        for (int i = 0; i < 8; i++) load(i, 32'h0010_0A00 + i);
        check_all("R1");

        // R4 examples, R2 low half
        load(3, 32'h1234_0A03); issue(3, 0, 2, 0, 3);
        check_reg(2, {16'h0010, 16'h5018}, "R4");
        // R2 high half, R7 low destination
        load(0, 32'h00B1_0000); issue(0, 1, 1, 0, 1);
        check_reg(1, {16'h0010, 16'h0162}, "R2");
        // R5 bit-15 case
        load(4, 32'hAAAA_0A04); issue(4, 0, 5, 1, 4);
        check_reg(5, {16'h7FFF, 16'h0A05}, "R5");
        // R6 negative clamp and exact minimum
        load(6, 32'h9000_FFFF); issue(6, 1, 6, 0, 1);
        check_reg(6, 32'h9000_8000, "R6");
        load(6, 32'h9000_FFFF); issue(6, 0, 6, 0, 15);
        check_reg(6, 32'h9000_8000, "R6");
        load(6, 32'hC800_0001); issue(6, 1, 6, 0, 6);
        check_reg(6, 32'hC800_8000, "R6");
        // R3 zero shift of negative
        load(7, 32'h8001_0000); issue(7, 1, 7, 0, 0);
        check_reg(7, 32'h8001_8001, "R3");
        // R8 same register, opposite half then back-to-back
        load(1, 32'h0000_0003); issue(1, 0, 1, 1, 2); issue(1, 1, 1, 0, 1);
        check_reg(1, 32'h000C_0018, "R8");
        // R9 load wins; instruction dropped
        ld_en = 1; ld_addr = 3'd2; ld_data = 32'h5555_5555;
        iss_valid = 1; iss_src = 3'd1; iss_src_hi = 0; iss_dst = 3'd3; iss_dst_hi = 0; iss_amt = 4'd1;
        @(negedge clk);
        ld_en = 0; iss_valid = 0; mdl[2] = 32'h5555_5555;
        check_all("R9");

        // random mix
        for (int n = 0; n < 600; n++) begin
            if ($urandom_range(0, 5) == 0) begin
                int a = $urandom_range(0, 7);
                load(a, {rand_half(), rand_half()});
                check_all("R1");
            end else begin
                int s = $urandom_range(0, 7), d = $urandom_range(0, 7), amt = $urandom_range(0, 15);
                bit shi = 1'($urandom_range(0, 1)), dhi = 1'($urandom_range(0, 1));
                string t = tag_of(shi ? mdl[s][31:16] : mdl[s][15:0], amt);
                issue(s, shi, d, dhi, amt);
                check_all(t);
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule